// File: doc/BRIEF.md
# Receive Special Character Detector

This block sits on the receive path of a serial port, between the deserializer that assembles incoming characters and the write port of the receive FIFO. Every character the deserializer completes is handed to the FIFO one clock later, unchanged, whatever the detector decides. The only effect of the detector is a status bit.

When detection is switched on, each completed character is compared with a programmable compare byte. The comparison covers only as many bits as the current character length: 5, 6, 7 or 8. If the character matches and arrived without a parity or framing error, a sticky flag is raised. The flag feeds the interrupt status register. It stays set until that register is read. If a new match arrives in the same cycle as the read, the flag stays set. Detection is off after reset.

Top module: `rx_special_detect`

## Requirements
- R1: After a synchronous reset, `fifo_we_o` is 0, `fifo_wdata_o` is 0 and `spc_flag_o` is 0. Detection is off until `det_en_i` is driven to 1.
- R2: Every cycle in which `rx_valid_i` is 1 produces exactly one FIFO write in the next cycle, with `fifo_wdata_o` equal to the received byte. This holds regardless of enable, match or error. A cycle without `rx_valid_i` produces no write in the next cycle.
- R3: A valid character raises `spc_flag_o` in the cycle after it arrives when all of the following hold:
  - `det_en_i` is 1.
  - `rx_err_i` is 0.
  - The masked character equals the masked `match_char_i`.
- R4: The compare mask follows `wlen_i`:
  - 0 compares bits 4:0.
  - 1 compares bits 5:0.
  - 2 compares bits 6:0.
  - 3 compares all eight bits.
  - Bits above the character length never affect the result.
- R5: A character received with `rx_err_i` = 1 never raises the flag.
- R6: While `det_en_i` is 0, the flag is never raised, and characters are still forwarded unchanged.
- R7: Once set, `spc_flag_o` stays 1 until a cycle with `stat_rd_i` = 1.
- R8: A cycle with `stat_rd_i` = 1 clears the flag in the next cycle. If a qualifying match is present in the same cycle as the read, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | Completed character strobe |
| rx_data_i | input | 8 | Completed character |
| rx_err_i | input | 1 | Parity or framing error on this character |
| det_en_i | input | 1 | Detection enable |
| wlen_i | input | 2 | Character length code (0..3 = 5..8 bits) |
| match_char_i | input | 8 | Compare byte |
| stat_rd_i | input | 1 | Interrupt status register read strobe |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write data |
| spc_flag_o | output | 1 | Sticky special-character flag |

## Verification
The assertions check the following on every cycle:
- the one-cycle write path and the data it carries;
- that an errored or disabled character never raises the flag;
- that the flag holds while unread;
- that a read clears the flag when no character is arriving.

The masking per character length and the correct set timing can only be confirmed by the bench. It compares against a reference model across the following scenarios:
- directed length cases;
- back-to-back matching and non-matching bytes;
- a read that collides with a match;
- a seeded random run.

// File: rtl/rx_spd_pkg.sv
package rx_spd_pkg;
  localparam int CHAR_W   = 8;
  localparam int WLEN_W   = 2;
  localparam int MIN_BITS = 5;

  typedef enum logic [WLEN_W-1:0] {
    WL_5 = 2'd0,
    WL_6 = 2'd1,
    WL_7 = 2'd2,
    WL_8 = 2'd3
  } wlen_e;
endpackage

// File: rtl/rsd_matcher.sv
module rsd_matcher #(
  parameter int CHAR_W   = rx_spd_pkg::CHAR_W,
  parameter int WLEN_W   = rx_spd_pkg::WLEN_W,
  parameter int MIN_BITS = rx_spd_pkg::MIN_BITS
) (
  input  logic [CHAR_W-1:0] char_i,
  input  logic [CHAR_W-1:0] ref_i,
  input  logic [WLEN_W-1:0] wlen_i,
  output logic              hit_o
);
  localparam int LEN_W = WLEN_W + 4;

  logic [CHAR_W-1:0] mask;
  logic [LEN_W-1:0]  nbits;

  assign nbits = LEN_W'(MIN_BITS) + LEN_W'(wlen_i);

  // bit k takes part in the comparison when it lies inside the character length
  for (genvar k = 0; k < CHAR_W; k++) begin : g_mask
    assign mask[k] = (LEN_W'(k) < nbits);
  end

  assign hit_o = ((char_i ^ ref_i) & mask) == '0;
endmodule

// File: rtl/rsd_flag.sv
module rsd_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)
      flag_o <= 1'b0;
    else if (set_i)
      flag_o <= 1'b1;
    else if (clr_i)
      flag_o <= 1'b0;
  end
endmodule

// File: rtl/rx_special_detect.sv
module rx_special_detect #(
  parameter int CHAR_W   = rx_spd_pkg::CHAR_W,
  parameter int WLEN_W   = rx_spd_pkg::WLEN_W,
  parameter int MIN_BITS = rx_spd_pkg::MIN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_err_i,
  input  logic              det_en_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic [CHAR_W-1:0] match_char_i,
  input  logic              stat_rd_i,
  output logic              fifo_we_o,
  output logic [CHAR_W-1:0] fifo_wdata_o,
  output logic              spc_flag_o
);
  logic hit;
  logic set_det;

  rsd_matcher #(
    .CHAR_W   (CHAR_W),
    .WLEN_W   (WLEN_W),
    .MIN_BITS (MIN_BITS)
  ) u_match (
    .char_i (rx_data_i),
    .ref_i  (match_char_i),
    .wlen_i (wlen_i),
    .hit_o  (hit)
  );

  assign set_det = rx_valid_i & det_en_i & ~rx_err_i & hit;

  rsd_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_det),
    .clr_i  (stat_rd_i),
    .flag_o (spc_flag_o)
  );

  // forwarding register: every character goes to the FIFO, matched or not
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_we_o    <= 1'b0;
      fifo_wdata_o <= '0;
    end else begin
      fifo_we_o <= rx_valid_i;
      if (rx_valid_i)
        fifo_wdata_o <= rx_data_i;
    end
  end
endmodule

// File: rtl/rx_special_detect_chk.sv
module rx_special_detect_chk #(
  parameter int CHAR_W = 8,
  parameter int WLEN_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid_i,
  input logic [CHAR_W-1:0] rx_data_i,
  input logic              rx_err_i,
  input logic              det_en_i,
  input logic [WLEN_W-1:0] wlen_i,
  input logic [CHAR_W-1:0] match_char_i,
  input logic              stat_rd_i,
  input logic              fifo_we_o,
  input logic [CHAR_W-1:0] fifo_wdata_o,
  input logic              spc_flag_o
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!spc_flag_o && !fifo_we_o)); // R1

  AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rx_valid_i |=> (fifo_we_o && fifo_wdata_o == $past(rx_data_i))); // R2

  AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_i |=> !fifo_we_o); // R2

  AST_ERR_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_i && rx_err_i) |=> !$rose(spc_flag_o)); // R5

  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !det_en_i |=> !$rose(spc_flag_o)); // R6

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (spc_flag_o && !stat_rd_i) |=> spc_flag_o); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !rx_valid_i) |=> !spc_flag_o); // R8
endmodule

bind rx_special_detect rx_special_detect_chk #(
  .CHAR_W (CHAR_W),
  .WLEN_W (WLEN_W)
) u_chk (.*);

// File: tb/test_rx_special_detect.sv
`timescale 1ns/1ps
module test_rx_special_detect;
  logic       clk = 1'b0;
  logic       rst;
  logic       rx_valid_i;
  logic [7:0] rx_data_i;
  logic       rx_err_i;
  logic       det_en_i;
  logic [1:0] wlen_i;
  logic [7:0] match_char_i;
  logic       stat_rd_i;
  logic       fifo_we_o;
  logic [7:0] fifo_wdata_o;
  logic       spc_flag_o;

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;
  bit  exp_flag;

  always #2.5 clk = ~clk;

  rx_special_detect i_rx_special_detect (.*);

  function automatic bit ref_hit(input logic [7:0] d, input logic [7:0] m,
                                 input logic [1:0] wl);
    logic [7:0] msk;
    msk = 8'hFF >> (3 - wl);
    return ((d ^ m) & msk) == 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns after the next posedge
  task automatic step(input bit v, input logic [7:0] d, input bit e, input bit en,
                      input logic [1:0] wl, input logic [7:0] m, input bit rd,
                      input string req);
    bit set;
    @(negedge clk);
    rx_valid_i = v; rx_data_i = d; rx_err_i = e; det_en_i = en;
    wlen_i = wl; match_char_i = m; stat_rd_i = rd;
    set = v && en && !e && ref_hit(d, m, wl);
    if (set) exp_flag = 1'b1;
    else if (rd) exp_flag = 1'b0;
    @(posedge clk); #1;
    chk({req, " R2 we"}, {7'd0, fifo_we_o}, {7'd0, v});
    if (v) chk({req, " R2 data"}, fifo_wdata_o, d);
    chk({req, " flag"}, {7'd0, spc_flag_o}, {7'd0, exp_flag});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    rst = 1'b1; rx_valid_i = 0; rx_data_i = 0; rx_err_i = 0; det_en_i = 0;
    wlen_i = 2'd3; match_char_i = 8'h13; stat_rd_i = 0; exp_flag = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 we", {7'd0, fifo_we_o}, 8'd0);
    chk("R1 data", fifo_wdata_o, 8'd0);
    chk("R1 flag", {7'd0, spc_flag_o}, 8'd0);
    @(negedge clk); rst = 1'b0;

    // R6: detection off after reset, matching byte forwarded, no flag
    step(1, 8'h13, 0, 0, 3, 8'h13, 0, "R6 off");
    step(0, 8'h00, 0, 0, 3, 8'h13, 0, "R6 idle");
    // R3 back-to-back match / non-match / match
    step(1, 8'h13, 0, 1, 3, 8'h13, 0, "R3 match");
    step(1, 8'h14, 0, 1, 3, 8'h13, 0, "R7 nonmatch holds");
    step(1, 8'h13, 0, 1, 3, 8'h13, 0, "R3 match again");
    step(0, 8'h00, 0, 1, 3, 8'h13, 1, "R8 read clears");
    // R5 errored match
    step(1, 8'h13, 1, 1, 3, 8'h13, 0, "R5 error");
    // R4 word-length masking
    step(1, 8'hE3, 0, 1, 0, 8'h03, 0, "R4 wl5 match");
    step(0, 8'h00, 0, 1, 0, 8'h03, 1, "R8 read");
    step(1, 8'hE3, 0, 1, 3, 8'h03, 0, "R4 wl8 nomatch");
    step(1, 8'hC5, 0, 1, 1, 8'h05, 0, "R4 wl6 match");
    step(0, 8'h00, 0, 1, 1, 8'h05, 1, "R8 read");
    step(1, 8'hA5, 0, 1, 1, 8'h05, 0, "R4 wl6 bit5 differs");
    step(1, 8'h85, 0, 1, 2, 8'h05, 0, "R4 wl7 match");
    // R8 read colliding with new match keeps flag
    step(1, 8'h05, 0, 1, 2, 8'h05, 1, "R8 read+match");
    step(0, 8'h00, 0, 1, 2, 8'h05, 1, "R8 final read");

    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] m, d;
      m = 8'($urandom);
      d = ($urandom_range(1, 0) == 1) ? (m ^ (8'($urandom) & 8'hE0)) : 8'($urandom);
      step(($urandom_range(3, 0) != 0), d, ($urandom_range(7, 0) == 0),
           ($urandom_range(5, 0) != 0), 2'($urandom), m,
           ($urandom_range(3, 0) == 0), "R3 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule